// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns a parallel byte into an asynchronous serial frame on one output line. A 16-bit divisor sets the bit rate. The divisor produces a clock enable that pulses once per sub-bit tick, 16 ticks to a bit. Four line-control inputs set the frame shape: a character length from five to eight bits, parity on or off, even or odd parity, and a short or long stop period.

Software-side logic writes a byte into a one-entry holding register. When the shifter is idle, the byte moves to the shifter on the next clock and its start bit begins at once. A byte written while a frame is in progress waits in the holding register. It is loaded at the clock edge that ends the current stop period, so the next start bit follows the stop bits with no idle gap. Two flags report state: one shows that the holding register can take a byte, the other shows that no frame is on the line.

Top module: `async_tx_core`

## Requirements
- R1: After reset, `txd` is high (mark), and `hold_empty` and `shift_empty` are both high.
- R2: A frame is sent as one low start bit, then the data bits least significant bit first, then the parity bit when enabled, then a high stop period.
- R3: `char_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only that many low-order bits of the byte are sent.
- R4: When `par_en` is 1, the parity bit makes the count of ones over the sent data bits plus the parity bit even when `par_odd` is 0, and odd when `par_odd` is 1.
- R5: The stop period lasts 16 ticks when `stop_long` is 0. When `stop_long` is 1 it lasts 32 ticks for characters of 6 to 8 bits and 24 ticks for 5-bit characters.
- R6: One tick equals `divisor` clock cycles, and a divisor of 0 acts as 1. Every bit lasts 16 ticks. `shift_empty` rises exactly (total frame ticks × effective divisor) cycles after `txd` falls for a start bit from idle.
- R7: A write sets the holding register full (`hold_empty` low). A byte written during a frame is loaded at the edge that ends the stop period: that edge starts the next start bit and raises `hold_empty`.
- R8: `shift_empty` is low from the clock that loads a byte into the shifter until the edge that ends a stop period with no byte waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Clock cycles per sub-bit tick (0 acts as 1) |
| char_len | input | 2 | Character length code (0..3 means 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_long | input | 1 | Long stop period (2 bits, or 1.5 bits for 5-bit characters) |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output line, high when idle |
| hold_empty | output | 1 | Holding register can take a byte |
| shift_empty | output | 1 | No frame in progress |

## Verification
The tick-spacing assertion assumes the divisor does not change between ticks, and it lets the check through on any cycle where the divisor has just changed. The line-control inputs are captured when a byte is loaded, so the frame checks assume they describe the frame in progress. The bench changes the divisor and line-control inputs only while `shift_empty` is high, and it writes at most one byte per frame, so the holding register is never overwritten. Every combination of character length, parity enable, parity sense and stop length is swept for divisors 0 to 3. Some frames are followed back to back by a second byte.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } tx_state_e;
endpackage

// File: rtl/utx_tick_gen.sv
module utx_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             restart,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] limit;

   if (DIV_W < 1) begin : g_bad_width
      $error("utx_tick_gen: DIV_W must be at least 1");
   end

   // zero divisor behaves as one: tick every cycle
   assign limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);
   assign tick  = (cnt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (restart || tick)  cnt <= '0;
      else                       cnt <= cnt + DIV_W'(1);
   end

   // R6: with an effective divisor above one, ticks never land on adjacent cycles
   assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && limit != '0) |=> (!tick || divisor != $past(divisor)));
endmodule

// File: rtl/utx_parity.sv
module utx_parity #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LEN_W-1:0]  len_code,
   input  logic              odd,
   output logic              par
);
   localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

   logic [DATA_W-1:0] mask;

   if (MIN_BITS < 1) begin : g_bad_len
      $error("utx_parity: length code range exceeds DATA_W");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i < MIN_BITS) begin : g_fixed
         assign mask[i] = 1'b1;
      end else begin : g_coded
         assign mask[i] = (len_code >= LEN_W'(i - MIN_BITS + 1));
      end
   end

   assign par = (^(data & mask)) ^ odd;
endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else begin
         if (wr_en) data <= wr_data;
         if (wr_en)     full <= 1'b1;
         else if (take) full <= 1'b0;
      end
   end

   // R7: a write always leaves the holding register occupied
   assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> full);
   // R7: a load with no new write frees the holding register
   assert_take_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> !full);
endmodule

// File: rtl/utx_frame.sv
module utx_frame
   import async_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LEN_W      = 2,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [LEN_W-1:0]  len_code,
   input  logic              par_en,
   input  logic              stop_long,
   input  logic              par_bit,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              take,
   output logic              restart,
   output logic              txd,
   output logic              busy
);
   localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;
   localparam int SUB_W    = $clog2(2 * OVERSAMPLE);
   localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int HALF     = OVERSAMPLE / 2;
   localparam logic [SUB_W-1:0] BIT_LAST   = SUB_W'(OVERSAMPLE - 1);
   localparam logic [SUB_W-1:0] STOP_ONE   = SUB_W'(OVERSAMPLE - 1);
   localparam logic [SUB_W-1:0] STOP_HALF  = SUB_W'(OVERSAMPLE + HALF - 1);
   localparam logic [SUB_W-1:0] STOP_TWO   = SUB_W'(2 * OVERSAMPLE - 1);

   tx_state_e         state;
   logic [SUB_W-1:0]  sub;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_idx;
   logic [DATA_W-1:0] shreg;
   logic              par_q;
   logic [LEN_W-1:0]  len_q;
   logic              pen_q;
   logic [SUB_W-1:0]  stop_last_q;
   logic [SUB_W-1:0]  stop_last_new;
   logic              txd_q;
   logic              stop_done;

   assign last_idx      = IDX_W'(MIN_BITS - 1) + IDX_W'(len_q);
   assign stop_last_new = !stop_long          ? STOP_ONE :
                          (len_code == '0)    ? STOP_HALF : STOP_TWO;
   assign stop_done     = (state == ST_STOP) && tick && (sub == stop_last_q);
   assign take          = hold_full && ((state == ST_IDLE) || stop_done);
   assign restart       = take && (state == ST_IDLE);
   assign txd           = txd_q;
   assign busy          = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         sub         <= '0;
         idx         <= '0;
         shreg       <= '0;
         par_q       <= 1'b0;
         len_q       <= '0;
         pen_q       <= 1'b0;
         stop_last_q <= STOP_ONE;
         txd_q       <= 1'b1;
      end else if (take) begin
         state       <= ST_START;
         sub         <= '0;
         idx         <= '0;
         shreg       <= hold_data;
         par_q       <= par_bit;
         len_q       <= len_code;
         pen_q       <= par_en;
         stop_last_q <= stop_last_new;
         txd_q       <= 1'b0;
      end else if (tick && state != ST_IDLE) begin
         if (state == ST_STOP) begin
            if (sub == stop_last_q) begin
               state <= ST_IDLE;
               sub   <= '0;
               txd_q <= 1'b1;
            end else begin
               sub <= sub + SUB_W'(1);
            end
         end else if (sub == BIT_LAST) begin
            sub <= '0;
            case (state)
               ST_START: begin
                  state <= ST_DATA;
                  txd_q <= shreg[0];
               end
               ST_DATA: begin
                  shreg <= shreg >> 1;
                  if (idx == last_idx) begin
                     if (pen_q) begin
                        state <= ST_PARITY;
                        txd_q <= par_q;
                     end else begin
                        state <= ST_STOP;
                        txd_q <= 1'b1;
                     end
                  end else begin
                     idx   <= idx + IDX_W'(1);
                     txd_q <= shreg[1];
                  end
               end
               ST_PARITY: begin
                  state <= ST_STOP;
                  txd_q <= 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end else begin
            sub <= sub + SUB_W'(1);
         end
      end
   end

   // R1: the line rests at mark whenever no frame is in progress
   assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> txd_q);
   // R2: the start slot always drives space
   assert_start_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START) |-> !txd_q);
   // R4: a parity slot only exists for frames loaded with parity enabled
   assert_parity_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PARITY) |-> pen_q);
   // R5: the stop period drives mark and never runs past its programmed length
   assert_stop_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP) |-> (txd_q && sub <= stop_last_q));
   // R8: loading a byte always leaves the shifter busy on the next cycle
   assert_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (state == ST_START));
endmodule

// File: rtl/async_tx_core.sv
module async_tx_core #(
   parameter int DATA_W     = 8,
   parameter int DIV_W      = 16,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [1:0]        char_len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop_long,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              hold_empty,
   output logic              shift_empty
);
   localparam int LEN_W = 2;

   if (DATA_W < (1 << LEN_W)) begin : g_bad_data
      $error("async_tx_core: DATA_W too small for the length code");
   end
   if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
      $error("async_tx_core: OVERSAMPLE must be even and at least 4");
   end

   logic              tick;
   logic              restart;
   logic              take;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              par_bit;
   logic              busy;

   utx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .restart (restart),
      .tick    (tick)
   );

   utx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .full    (hold_full),
      .data    (hold_data)
   );

   utx_parity #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_par (
      .data     (hold_data),
      .len_code (char_len),
      .odd      (par_odd),
      .par      (par_bit)
   );

   utx_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .len_code  (char_len),
      .par_en    (par_en),
      .stop_long (stop_long),
      .par_bit   (par_bit),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .take      (take),
      .restart   (restart),
      .txd       (txd),
      .busy      (busy)
   );

   assign hold_empty  = !hold_full;
   assign shift_empty = !busy;
endmodule

// File: tb/sim_async_tx_core.sv
module sim_async_tx_core;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] divisor;
   logic [1:0]  char_len;
   logic        par_en, par_odd, stop_long;
   logic        wr_en;
   logic [7:0]  wr_data;
   logic        txd, hold_empty, shift_empty;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   async_tx_core u0 (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .char_len(char_len),
      .par_en(par_en), .par_odd(par_odd), .stop_long(stop_long),
      .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
      .hold_empty(hold_empty), .shift_empty(shift_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_byte(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Starts at the negedge right after the start bit began (elapsed 0).
   task automatic check_frame(input int eff, input int nb, input bit pen, input bit podd,
                              input bit slong, input logic [7:0] d,
                              input bit pend, input logic [7:0] d2);
      int el;
      int total;
      int stop_t;
      int ones;
      bit pexp;
      el = 0;
      stop_t = !slong ? 16 : (nb == 5 ? 24 : 32);
      total  = 16 * (1 + nb + (pen ? 1 : 0)) + stop_t;
      ones = 0;
      for (int k = 0; k < nb; k++) ones += int'(d[k]);
      pexp = ((ones % 2) == 1) ^ podd;
      step(8 * eff); el = 8 * eff;
      chk(txd == 1'b0, "R2 start bit low", int'(txd), 0);
      if (pend) begin
         write_byte(d2); el += 1;
         chk(hold_empty == 1'b0, "R7 byte held while busy", int'(hold_empty), 0);
      end
      for (int k = 0; k < nb; k++) begin
         step((16 * (k + 1) + 8) * eff - el); el = (16 * (k + 1) + 8) * eff;
         chk(txd == d[k], "R3 data bit lsb first", int'(txd), int'(d[k]));
      end
      if (pen) begin
         step((16 * (nb + 1) + 8) * eff - el); el = (16 * (nb + 1) + 8) * eff;
         chk(txd == pexp, "R4 parity bit", int'(txd), int'(pexp));
      end
      step(total * eff - 1 - el); el = total * eff - 1;
      chk(txd == 1'b1, "R5 stop still mark at last cycle", int'(txd), 1);
      chk(shift_empty == 1'b0, "R8 busy through stop", int'(shift_empty), 0);
      step(1);
      if (pend) begin
         chk(txd == 1'b0, "R7 next start follows stop", int'(txd), 0);
         chk(hold_empty == 1'b1, "R7 hold empties on load", int'(hold_empty), 1);
         chk(shift_empty == 1'b0, "R8 busy on back-to-back", int'(shift_empty), 0);
      end else begin
         chk(shift_empty == 1'b1, "R6 frame length in cycles", int'(shift_empty), 1);
         chk(txd == 1'b1, "R1 line returns to mark", int'(txd), 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; divisor = 16'd1; char_len = 2'd3;
      par_en = 1'b0; par_odd = 1'b0; stop_long = 1'b0;
      wr_en = 1'b0; wr_data = 8'h00;
      step(4);
      rst_n = 1'b1;
      step(1);
      chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
      chk(hold_empty == 1'b1, "R1 reset hold_empty", int'(hold_empty), 1);
      chk(shift_empty == 1'b1, "R1 reset shift_empty", int'(shift_empty), 1);

      for (int dv = 0; dv < 4; dv++) begin
         for (int c = 0; c < 32; c++) begin
            int eff;
            int nb;
            bit pend;
            logic [7:0] d;
            logic [7:0] d2;
            eff = (dv == 0) ? 1 : dv;
            divisor   = 16'(dv);
            char_len  = 2'(c % 4);
            par_en    = c[2];
            par_odd   = c[3];
            stop_long = c[4];
            nb   = 5 + (c % 4);
            d    = 8'((dv * 32 + c) * 73 + 53);
            d2   = d ^ 8'hA5;
            pend = ((c % 4) == 3) || (c == 8);
            write_byte(d);
            chk(hold_empty == 1'b0, "R7 write fills hold", int'(hold_empty), 0);
            step(1);
            chk(txd == 1'b0, "R2 start from idle", int'(txd), 0);
            chk(shift_empty == 1'b0, "R8 busy after load", int'(shift_empty), 0);
            chk(hold_empty == 1'b1, "R7 hold empties at idle load", int'(hold_empty), 1);
            check_frame(eff, nb, c[2], c[3], c[4], d, pend, d2);
            if (pend) check_frame(eff, nb, c[2], c[3], c[4], d2, 1'b0, 8'h00);
            step(2);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule